// File: doc/BRIEF.md
# Pipelined Burst SRAM

A synchronous 32-bit memory model with a pipelined read path, byte-granular writes and a two-bit burst counter. Every control input is sampled on the rising clock edge. An access opens with an address strobe, either from the processor side or from the controller side. The address and the chip-select decode are held from that strobe onward. Later cycles without a strobe continue the burst. The low two address bits step forward, wrapping within a group of four, only in cycles where the advance input is asserted.

Write controls are decoded into a four-bit lane mask. A global write covers all lanes, and individual byte enables take effect under a byte-write master enable. Address, data and mask are registered into a request stage and committed one edge later. A read issued right after a write therefore returns the new data. Read data passes through an output register. A drive-enable flag follows the same pipeline, so a deselected or write access turns the data drivers off one stage later. The output enable gates that flag without a clock. A snooze input makes the block ignore every operation.

The array depth is set by the address-width parameter.

Top module: `pburst_sram`

## Requirements
- R1: After reset, `rdata_oe_o` is 0 and `rdata_o` is 0.
- R2: An address strobe selects the device only when `ce_ni`=0, `ce2_i`=1 and `ce3_ni`=0. Otherwise the strobe and the following burst cycles neither write nor drive read data.
- R3: A strobe captures `addr_i`. When `ads_proc_ni`=0 the cycle is a read, even if write controls are asserted. Only `ads_ctrl_ni`=0 alone can start a write.
- R4: In a cycle with no strobe, address bits [1:0] advance by one (3 wraps to 0) when `adv_ni`=0, and hold when `adv_ni`=1. The upper bits never change.
- R5: With `gw_ni`=1 and `bwe_ni`=0, `be_ni[0]` low writes bits 7:0, `be_ni[1]` bits 15:8, `be_ni[2]` bits 23:16 and `be_ni[3]` bits 31:24. Other lanes keep their contents. With `bwe_ni`=1 and `gw_ni`=1 the cycle is a read.
- R6: `gw_ni`=0 writes all four lanes, whatever `be_ni` and `bwe_ni` hold.
- R7: A read sampled at edge k presents its data on `rdata_o` with `rdata_oe_o`=1 after edge k+1.
- R8: A read at edge k+1 of the address written at edge k returns the written data.
- R9: After edge k+1, `rdata_oe_o` is 0 whenever the access at edge k was a write, was deselected, or was ignored.
- R10: `oe_ni`=1 forces `rdata_oe_o` to 0 at once, with no clock edge, and releasing it restores the drive.
- R11: While `snooze_i`=1 at an edge, nothing is captured, nothing is written and no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| ads_proc_ni | input | 1 | Processor-side address strobe, active low |
| ads_ctrl_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Expansion enable, active high |
| ce3_ni | input | 1 | Expansion enable, active low |
| be_ni | input | 4 | Byte enables, active low, bit n for lane n |
| bwe_ni | input | 1 | Byte-write master enable, active low |
| gw_ni | input | 1 | Global write, active low |
| wdata_i | input | 32 | Write data |
| oe_ni | input | 1 | Output enable, active low, unclocked |
| snooze_i | input | 1 | Ignore all operations |
| rdata_o | output | 32 | Registered read data |
| rdata_oe_o | output | 1 | Data drive enable |

## Verification
Two pairs of functions can land in the same cycle. A processor strobe can come with a global write, and a read can come on the edge right after a write to the same word. The bench drives both back to back. It checks that the strobe cycle drives old data and leaves memory untouched, and that the following read returns the freshly merged word. A reference model in the bench follows the burst address and lane contents. A scoreboard compares every cycle's drive enable and data two edges after issue.

// File: rtl/pburst_sram_pkg.sv
package pburst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int CNT_W  = 2;
endpackage

// File: rtl/pburst_sram_addr.sv
module pburst_sram_addr #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          snooze_i,
  input  logic          strobe_i,
  input  logic [AW-1:0] addr_i,
  input  logic          adv_ni,
  input  logic          sel_i,
  output logic [AW-1:0] acc_addr_o,
  output logic          acc_sel_o
);
  import pburst_sram_pkg::*;

  logic [AW-1:0] addr_q;
  logic          sel_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = addr_q[CNT_W-1:0] + CNT_W'(1);

  always_comb begin
    if (strobe_i) begin
      acc_addr_o = addr_i;
      acc_sel_o  = sel_i;
    end else begin
      acc_addr_o = adv_ni ? addr_q : {addr_q[AW-1:CNT_W], cnt_nxt};
      acc_sel_o  = sel_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
    end else if (!snooze_i) begin
      addr_q <= acc_addr_o;
      sel_q  <= acc_sel_o;
    end
  end

  p_hi_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !snooze_i) |=> (addr_q[AW-1:CNT_W] == $past(addr_q[AW-1:CNT_W])));
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !snooze_i && !adv_ni) |=> (addr_q[CNT_W-1:0] == $past(addr_q[CNT_W-1:0]) + CNT_W'(1)));
  p_snooze_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snooze_i |=> ($stable(addr_q) && $stable(sel_q)));
endmodule

// File: rtl/pburst_sram_wdec.sv
module pburst_sram_wdec
  import pburst_sram_pkg::*;
(
  input  logic             force_rd_i,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] be_ni,
  output logic [LANES-1:0] mask_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_dec
    assign mask_o[g] = !force_rd_i && (!gw_ni || (!bwe_ni && !be_ni[g]));
  end
endmodule

// File: rtl/pburst_sram_lane.sv
module pburst_sram_lane #(
  parameter int AW = 10,
  parameter int W  = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wd_i,
  output logic [W-1:0]  rd_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wd_i;
  end

  assign rd_o = mem[addr_i];
endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
  import pburst_sram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              ads_proc_ni,
  input  logic              ads_ctrl_ni,
  input  logic              adv_ni,
  input  logic              ce_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic [LANES-1:0]  be_ni,
  input  logic              bwe_ni,
  input  logic              gw_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oe_ni,
  input  logic              snooze_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  logic              strobe, sel_dec, acc_sel, acc_go;
  logic [AW-1:0]     acc_addr;
  logic [LANES-1:0]  wmask;

  logic              req_rd_q, req_we_q;
  logic [LANES-1:0]  req_mask_q;
  logic [AW-1:0]     req_addr_q;
  logic [DATA_W-1:0] req_data_q;
  logic [DATA_W-1:0] lane_rd;

  logic              out_sel_q;
  logic [DATA_W-1:0] out_data_q;

  assign strobe  = !ads_proc_ni || !ads_ctrl_ni;
  assign sel_dec = !ce_ni && ce2_i && !ce3_ni;

  pburst_sram_addr #(.AW(AW)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .snooze_i   (snooze_i),
    .strobe_i   (strobe),
    .addr_i     (addr_i),
    .adv_ni     (adv_ni),
    .sel_i      (sel_dec),
    .acc_addr_o (acc_addr),
    .acc_sel_o  (acc_sel)
  );

  // processor strobe wins and forces a read
  pburst_sram_wdec u_wdec (
    .force_rd_i (!ads_proc_ni),
    .gw_ni      (gw_ni),
    .bwe_ni     (bwe_ni),
    .be_ni      (be_ni),
    .mask_o     (wmask)
  );

  assign acc_go = acc_sel && !snooze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_rd_q   <= 1'b0;
      req_we_q   <= 1'b0;
      req_mask_q <= '0;
      req_addr_q <= '0;
      req_data_q <= '0;
    end else begin
      req_rd_q   <= acc_go && (wmask == '0);
      req_we_q   <= acc_go && (wmask != '0);
      req_mask_q <= wmask;
      req_addr_q <= acc_addr;
      req_data_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pburst_sram_lane #(.AW(AW), .W(LANE_W)) u_lane (
      .clk_i  (clk_i),
      .we_i   (req_we_q && req_mask_q[g]),
      .addr_i (req_addr_q),
      .wd_i   (req_data_q[g*LANE_W +: LANE_W]),
      .rd_o   (lane_rd[g*LANE_W +: LANE_W])
    );
  end

  // write commits at the same edge a following read would sample, so no bypass mux
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_sel_q  <= 1'b0;
      out_data_q <= '0;
    end else begin
      out_sel_q <= req_rd_q;
      if (req_rd_q) out_data_q <= lane_rd;
    end
  end

  assign rdata_o    = out_data_q;
  assign rdata_oe_o = out_sel_q && !oe_ni;

  p_proc_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_proc_ni && !snooze_i) |=> !req_we_q);
  p_gw_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_sel && !snooze_i && !gw_ni && ads_proc_ni) |=> (req_we_q && (req_mask_q == '1)));
  p_desel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !sel_dec && !snooze_i) |=> (!req_rd_q && !req_we_q));
  p_pipe_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_rd_q |=> !out_sel_q);
  p_snooze_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snooze_i |=> (!req_rd_q && !req_we_q));
endmodule

// File: tb/pburst_sram_test.sv
module pburst_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int TIMEOUT = 200000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ads_proc_ni = 1'b1, ads_ctrl_ni = 1'b1, adv_ni = 1'b1;
  logic          ce_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1;
  logic [3:0]    be_ni = 4'hF;
  logic          bwe_ni = 1'b1, gw_ni = 1'b1;
  logic [31:0]   wdata_i = '0;
  logic          oe_ni = 1'b0, snooze_i = 1'b0;
  logic [31:0]   rdata_o;
  logic          rdata_oe_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    bit          oe;
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [31:0]   ref_mem [1<<AW];
  logic [AW-1:0] m_addr = '0;
  bit            m_sel = 0;

  localparam logic [2:0] SEL   = 3'b010; // {ce3_ni, ce2_i, ce_ni}
  localparam logic [2:0] DESC2 = 3'b000;
  localparam logic [2:0] DESC3 = 3'b110;

  pburst_sram #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i),
    .ads_proc_ni(ads_proc_ni), .ads_ctrl_ni(ads_ctrl_ni), .adv_ni(adv_ni),
    .ce_ni(ce_ni), .ce2_i(ce2_i), .ce3_ni(ce3_ni), .be_ni(be_ni),
    .bwe_ni(bwe_ni), .gw_ni(gw_ni), .wdata_i(wdata_i), .oe_ni(oe_ni),
    .snooze_i(snooze_i), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop
  always @(negedge clk) begin
    if (rst_ni) begin
      while (q.size() > 0 && q[0].due == cyc) begin
        check(rdata_oe_o == q[0].oe, {q[0].tag, " oe"}, 32'(rdata_oe_o), 32'(q[0].oe));
        if (q[0].oe) check(rdata_o === q[0].d, {q[0].tag, " data"}, rdata_o, q[0].d);
        void'(q.pop_front());
      end
    end
  end

  // driver: ps/cs/adv/gw/bwe/be are active-high here
  task automatic step(input bit ps, input bit cs, input bit adv, input logic [2:0] ce,
                      input bit gw, input bit bwe, input logic [3:0] be,
                      input logic [AW-1:0] a, input logic [31:0] d, input bit snz,
                      input string tag);
    logic [3:0] mask;
    bit rd;
    exp_t e;
    @(negedge clk);
    ads_proc_ni = !ps; ads_ctrl_ni = !cs; adv_ni = !adv;
    {ce3_ni, ce2_i, ce_ni} = ce;
    gw_ni = !gw; bwe_ni = !bwe; be_ni = ~be;
    addr_i = a; wdata_i = d; snooze_i = snz;
    rd = 0;
    if (!snz) begin
      if (ps || cs) begin
        m_addr = a;
        m_sel = (ce == SEL);
      end else if (adv) begin
        m_addr = {m_addr[AW-1:2], m_addr[1:0] + 2'd1};
      end
      mask = ps ? 4'h0 : gw ? 4'hF : bwe ? be : 4'h0;
      if (m_sel && mask != 0)
        for (int l = 0; l < 4; l++)
          if (mask[l]) ref_mem[m_addr][l*8 +: 8] = d[l*8 +: 8];
      rd = m_sel && (mask == 0);
    end
    e.due = cyc + 2; e.oe = rd; e.d = ref_mem[m_addr]; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    step(0, 1, 0, SEL, 1, 0, 4'h0, a, d, 0, tag);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1, 0, 0, SEL, 0, 0, 4'h0, a, '0, 0, tag);
  endtask
  task automatic cont(input bit adv, input string tag);
    step(0, 0, adv, SEL, 0, 0, 4'h0, '0, '0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * TIMEOUT);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdata_oe_o == 1'b0, "R1 oe", 32'(rdata_oe_o), 32'h0);
    check(rdata_o == '0, "R1 data", rdata_o, 32'h0);
    rst_ni = 1'b1;
    cont(0, "R1 idle");
    cont(0, "R1 idle");

    // R6 global write, R8 pass-through, R7 latency
    wr(10'h010, 32'hCAFE_0001, "R6 gw write");
    rd(10'h010, "R8 read after write");
    cont(0, "R7 hold read");

    // R5 byte lanes
    wr(10'h020, 32'h1122_3344, "R6 base");
    step(0, 1, 0, SEL, 0, 1, 4'b0101, 10'h020, 32'hAABB_CCDD, 0, "R5 lanes 0,2");
    rd(10'h020, "R5 merged 0,2");
    step(0, 1, 0, SEL, 0, 1, 4'b1000, 10'h020, 32'h5500_0000, 0, "R5 lane 3");
    rd(10'h020, "R5 merged 3");
    step(0, 1, 0, SEL, 0, 0, 4'b1111, 10'h020, 32'hFFFF_FFFF, 0, "R5 bwe off read");
    step(0, 1, 0, SEL, 1, 0, 4'b0000, 10'h024, 32'h0BAD_F00D, 0, "R6 gw ignores be");
    rd(10'h024, "R6 gw readback");

    // R4 burst with wrap
    wr(10'h032, 32'h0000_0032, "R4 burst w0");
    step(0, 0, 1, SEL, 1, 0, 4'h0, '0, 32'h0000_0033, 0, "R4 burst w1");
    step(0, 0, 1, SEL, 1, 0, 4'h0, '0, 32'h0000_0030, 0, "R4 burst w2 wrap");
    step(0, 0, 1, SEL, 1, 0, 4'h0, '0, 32'h0000_0031, 0, "R4 burst w3");
    rd(10'h032, "R4 burst r0");
    cont(1, "R4 burst r1");
    cont(1, "R4 burst r2 wrap");
    cont(0, "R4 burst hold");
    cont(1, "R4 burst r3");
    cont(1, "R4 burst r4 back");

    // R3 processor strobe wins over global write
    step(1, 1, 0, SEL, 1, 0, 4'h0, 10'h010, 32'hDEAD_DEAD, 0, "R3 proc strobe read");
    rd(10'h010, "R3 no write");

    // R2/R9 deselected access
    step(0, 1, 0, DESC2, 1, 0, 4'h0, 10'h010, 32'h1111_1111, 0, "R9 deselect ce2 off");
    step(0, 0, 1, DESC2, 1, 0, 4'h0, '0, 32'h2222_2222, 0, "R2 desel burst");
    step(1, 0, 0, DESC3, 0, 0, 4'h0, 10'h010, '0, 0, "R2 desel ce3 read");
    rd(10'h010, "R2 unchanged");

    // R11 snooze
    step(0, 1, 0, SEL, 1, 0, 4'h0, 10'h010, 32'h3333_3333, 1, "R11 snooze write");
    step(1, 0, 0, SEL, 0, 0, 4'h0, 10'h024, '0, 1, "R11 snooze read");
    cont(0, "R11 addr kept");
    rd(10'h010, "R11 unchanged");

    // R9 write turns drive off
    wr(10'h040, 32'h4040_4040, "R9 write no drive");
    rd(10'h040, "R8 read after write 2");
    cont(0, "R10 setup");
    cont(0, "R10 setup");
    // R10 asynchronous output enable
    #2 oe_ni = 1'b1;
    #1 check(rdata_oe_o == 1'b0, "R10 oe off", 32'(rdata_oe_o), 32'h0);
    oe_ni = 1'b0;
    #1 check(rdata_oe_o == 1'b1, "R10 oe on", 32'(rdata_oe_o), 32'h1);

    repeat (4) cont(0, "R7 drain");
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R7 queue drained", 32'(q.size()), 32'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule